// File: doc/BRIEF.md
# Mixed-Width Instruction Fetch Unit

This unit fetches one instruction per start request for a processor that runs either a fixed 32-bit instruction set or a compact set whose instructions are 16 or 32 bits long. When a start is accepted, the unit first settles the effective mode. It looks at whether the core is the oldest supported architecture version, at the mode that was asked for, and at two feature-presence flags. A mode that cannot be served is either mapped to a fallback or rejected with an error.

It then reads memory at the program counter. In fixed mode it makes one 32-bit word read. In compact mode it reads one halfword and uses that halfword's top five bits to decide whether a second halfword is needed at PC+2. The finished instruction is put out with an encoding tag and an extended-interpretation flag for the decoder. A one-cycle done pulse marks each result.

Memory reads use a request/valid scheme. The unit holds `mem_req` with a stable address and width until `mem_rvalid` is seen in the same cycle. Halfword data arrives on bits [15:0] of `mem_rdata`.

Top module: `ifetch_mixed`

## Requirements
- R1: A synchronous reset puts the unit in idle. After reset `done`, `err`, `busy` and `mem_req` are 0, `insn` is 0 and `enc` is 0. A reset during a fetch abandons that fetch.
- R2: When `arch_old` is 1, the fetch is a single 32-bit word read, whatever `req_mode` holds (mode codes: 0 fixed, 1 compact, 2 extended compact, 3 bytecode). No error is raised, even for mode 3.
- R3: With `arch_old` 0, mode 3 and `has_bytecode` 0, the fetch is performed as fixed mode.
- R4: With `arch_old` 0, mode 3 and `has_bytecode` 1, no memory read is made. `done` and `err` rise together in the cycle after start, with `insn`, `enc` and `ext_flag` cleared to 0. `err` stays 0 from the next accepted start onward until another rejection.
- R5: Mode 2 with `has_ext` 0 is fetched as plain compact mode, so `ext_flag` stays 0.
- R6: In fixed mode, one read is made with `mem_wide` 1 at `mem_addr` = PC. `insn` is the returned word and `enc` is 0.
- R7: In compact mode the first read has `mem_wide` 0 at PC. The instruction is 32 bits long exactly when bits [15:13] of the first halfword are 3'b111 and bits [12:11] are not 2'b00. Otherwise it is 16 bits long, with `enc` 1 and `insn` = {16'h0, halfword}.
- R8: For a 32-bit compact instruction, a second halfword read is made at PC+2, modulo the address width. `insn` = {first, second} and `enc` is 2.
- R9: `ext_flag` is 1 only for a 16-bit instruction fetched in extended compact mode with `has_ext` 1, and 0 for every other result.
- R10: `done` rises for exactly one cycle, in the cycle after the last read response is accepted. `insn`, `enc` and `ext_flag` change only in a cycle where `done` is 1.
- R11: `start` is ignored while `busy` is 1. `busy` is 1 from acceptance through the done cycle.
- R12: While `mem_req` is 1 and no response has arrived, `mem_req`, `mem_addr` and `mem_wide` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one fetch |
| arch_old | input | 1 | Core is the oldest supported architecture version |
| req_mode | input | 2 | Requested mode: 0 fixed, 1 compact, 2 extended compact, 3 bytecode |
| has_bytecode | input | 1 | Bytecode execution feature present |
| has_ext | input | 1 | Compact-set extension present |
| pc | input | AW | Program counter, sampled at start |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | AW | Read byte address |
| mem_wide | output | 1 | 1 for a 32-bit word read, 0 for a halfword read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data; halfwords on [15:0] |
| busy | output | 1 | Fetch in progress or result being reported |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last request was rejected |
| insn | output | 32 | Instruction bits |
| enc | output | 2 | Encoding: 0 fixed 32-bit, 1 compact 16-bit, 2 compact 32-bit |
| ext_flag | output | 1 | Decode with the extended interpretation |

## Verification
The bench targets the length rule at its edges. It uses a first halfword with bits [15:13] all ones and bits [12:11] zero, which must stay short, next to neighbours that must go long. A design that tested only the top three bits would issue a spurious second read there.

It also targets the mode-resolution ordering. An old core asking for bytecode with the feature present must not raise an error. The bench checks that the extension flag never appears for 32-bit instructions or when the extension is absent. A PC at the top of the address space checks that the PC+2 read wraps.

Random response latencies and start pulses during a fetch and during the done cycle would expose a design that re-samples the PC or stretches `done`. A design that exposes the first halfword before completion would trip the output-hold check.

// File: rtl/ifetch_mixed.sv
module ifetch_mixed #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          arch_old,
  input  logic [1:0]    req_mode,
  input  logic          has_bytecode,
  input  logic          has_ext,
  input  logic [AW-1:0] pc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wide,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   insn,
  output logic [1:0]    enc,
  output logic          ext_flag
);
  localparam logic [1:0] M_FIX = 2'd0, M_CMP = 2'd1, M_EXT = 2'd2, M_BC = 2'd3;
  localparam logic [1:0] E_W32 = 2'd0, E_H16 = 2'd1, E_H32 = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WORD, S_HW1, S_HW2} st_t;

  st_t           state;
  logic [AW-1:0] pc_q;
  logic [15:0]   hw1_q;
  logic          ext_q;
  logic [1:0]    eff;
  logic          reject;

  always_comb begin
    eff    = req_mode;
    reject = 1'b0;
    if (arch_old) eff = M_FIX;
    else begin
      case (req_mode)
        M_BC:  begin eff = M_FIX; reject = has_bytecode; end
        M_EXT: if (!has_ext) eff = M_CMP;
        default: ;
      endcase
    end
  end

  wire [15:0] first_hw = mem_rdata[15:0];
  wire        is_long  = (first_hw[15:13] == 3'b111) && (first_hw[12:11] != 2'b00);
  wire        accept   = start && (state == S_IDLE) && !done;
  wire        rsp      = mem_req && mem_rvalid;

  assign mem_req  = (state != S_IDLE);
  assign mem_wide = (state == S_WORD);
  assign mem_addr = (state == S_HW2) ? pc_q + AW'(2) : pc_q;
  assign busy     = (state != S_IDLE) || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pc_q     <= '0;
      hw1_q    <= '0;
      ext_q    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      insn     <= '0;
      enc      <= E_W32;
      ext_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          pc_q <= pc;
          if (reject) begin
            done     <= 1'b1;
            err      <= 1'b1;
            insn     <= '0;
            enc      <= E_W32;
            ext_flag <= 1'b0;
          end else begin
            err   <= 1'b0;
            ext_q <= (eff == M_EXT);
            state <= (eff == M_FIX) ? S_WORD : S_HW1;
          end
        end
        S_WORD: if (rsp) begin
          insn     <= mem_rdata;
          enc      <= E_W32;
          ext_flag <= 1'b0;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        S_HW1: if (rsp) begin
          if (is_long) begin
            hw1_q <= first_hw;
            state <= S_HW2;
          end else begin
            insn     <= {16'h0000, first_hw};
            enc      <= E_H16;
            ext_flag <= ext_q;
            done     <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_HW2: if (rsp) begin
          insn     <= {hw1_q, mem_rdata[15:0]};
          enc      <= E_H32;
          ext_flag <= 1'b0;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module ifetch_mixed_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_wide,
  input logic          done,
  input logic          err,
  input logic [31:0]   insn,
  input logic [1:0]    enc,
  input logic          ext_flag
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_out_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(insn) && $stable(enc) && $stable(ext_flag)));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_wide)));

  p_err_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !err);

  p_busy_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_ext_short_r9: assert property (@(posedge clk) disable iff (rst)
    ext_flag |-> (enc == 2'd1));
endmodule

bind ifetch_mixed ifetch_mixed_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .mem_addr(mem_addr), .mem_wide(mem_wide),
  .done(done), .err(err), .insn(insn), .enc(enc), .ext_flag(ext_flag)
);

// File: tb/ifetch_mixed_tb.sv
`timescale 1ns/1ps
module ifetch_mixed_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, arch_old = 1'b0, has_bytecode = 1'b0, has_ext = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [31:0] pc = '0;
  logic        mem_req, mem_wide, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, done, err, ext_flag;
  logic [31:0] insn;
  logic [1:0]  enc;
  int n_vec = 0, n_err = 0;

  always #10 clk = ~clk;

  ifetch_mixed #(.AW(32)) u_dut (
    .clk(clk), .rst(rst), .start(start), .arch_old(arch_old), .req_mode(req_mode),
    .has_bytecode(has_bytecode), .has_ext(has_ext), .pc(pc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wide(mem_wide), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err), .insn(insn),
    .enc(enc), .ext_flag(ext_flag)
  );

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic fetch(input bit old, input logic [1:0] m, input bit hb, input bit he,
                       input logic [31:0] p, input logic [31:0] w,
                       input logic [15:0] h1, input logic [15:0] h2,
                       input int lat, input bit poke, input string rq);
    logic [31:0] ea[2];
    bit          ew[2];
    logic [31:0] ed[2];
    int nrd = 0, idx = 0, wc = 0;
    logic [31:0] xi = '0;
    logic [1:0]  xe = 2'd0, em;
    bit xx = 0, xr = 0, fin = 0, pend, lng;
    em = m;
    if (old) em = 2'd0;
    else if (m == 2'd3) begin em = 2'd0; xr = hb; end
    else if (m == 2'd2 && !he) em = 2'd1;
    if (!xr) begin
      if (em == 2'd0) begin
        ea[0] = p; ew[0] = 1; ed[0] = w; nrd = 1; xi = w; xe = 2'd0;
      end else begin
        lng = (h1[15:13] == 3'b111) && (h1[12:11] != 2'b00);
        ea[0] = p; ew[0] = 0; ed[0] = {~h1, h1}; nrd = 1;
        if (lng) begin
          ea[1] = p + 32'd2; ew[1] = 0; ed[1] = {~h2, h2}; nrd = 2;
          xi = {h1, h2}; xe = 2'd2;
        end else begin
          xi = {16'h0000, h1}; xe = 2'd1; xx = (em == 2'd2);
        end
      end
    end
    @(negedge clk);
    arch_old = old; req_mode = m; has_bytecode = hb; has_ext = he; pc = p; start = 1;
    @(negedge clk);
    start = 0;
    pend = xr;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      if (poke && cyc == 0) begin start = 1; pc = p + 32'h40; end
      if (poke && cyc == 1) start = 0;
      if (mem_rvalid) begin
        mem_rvalid = 0; idx++; wc = 0;
        if (idx == nrd) pend = 1;
      end
      chk(done === pend, {rq, " R10 done timing"}, done, pend);
      if (done) begin
        fin = 1;
        chk(insn === xi, {rq, " insn"}, insn, xi);
        chk(enc === xe, {rq, " enc"}, enc, xe);
        chk(ext_flag === xx, {rq, " R9 ext_flag"}, ext_flag, xx);
        chk(err === xr, {rq, " R4 err"}, err, xr);
      end else if (pend) begin
        fin = 1;
      end else if (mem_req) begin
        if (idx >= nrd) begin
          chk(0, {rq, " R4 unexpected read"}, mem_addr, 0);
          fin = 1;
        end else begin
          if (wc == 0) begin
            chk(mem_addr === ea[idx], {rq, " R8 read address"}, mem_addr, ea[idx]);
            chk(mem_wide === ew[idx], {rq, " R6 read width"}, mem_wide, ew[idx]);
          end
          if (wc == lat) begin mem_rvalid = 1; mem_rdata = ed[idx]; end
          else wc++;
        end
      end
      if (!fin) @(negedge clk);
    end
    if (!fin) chk(0, {rq, " R10 no done"}, 0, 1);
    if (poke) start = 1;
    @(negedge clk);
    start = 0;
    chk(done === 1'b0, {rq, " R10 done one cycle"}, done, 0);
    chk(mem_req === 1'b0, {rq, " R11 start in done cycle ignored"}, mem_req, 0);
    chk(insn === xi, {rq, " R10 insn held"}, insn, xi);
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 0 && err === 0 && busy === 0 && mem_req === 0, "R1 reset flags",
        {done, err, busy, mem_req}, 0);
    chk(insn === 0 && enc === 0, "R1 reset outputs", {insn, enc}, 0);
    rst = 0;

    fetch(0, 2'd0, 0, 0, 32'h0000_0100, 32'hE3A0_1234, 16'h0, 16'h0, 0, 0, "R6");
    fetch(1, 2'd1, 0, 1, 32'h0000_0200, 32'h1122_3344, 16'hF000, 16'h0, 2, 0, "R2");
    fetch(1, 2'd3, 1, 0, 32'h0000_0204, 32'h5566_7788, 16'h0, 16'h0, 1, 0, "R2");
    fetch(0, 2'd3, 0, 0, 32'h0000_0300, 32'h99AA_BBCC, 16'h0, 16'h0, 0, 0, "R3");
    fetch(0, 2'd3, 1, 0, 32'h0000_0304, 32'h0, 16'h0, 16'h0, 0, 0, "R4");
    fetch(0, 2'd1, 0, 0, 32'h0000_0400, 32'h0, 16'hE000, 16'h0, 1, 0, "R7");
    fetch(0, 2'd1, 0, 0, 32'h0000_0402, 32'h0, 16'hF000, 16'h8000, 0, 0, "R8");
    fetch(0, 2'd1, 0, 0, 32'h0000_0410, 32'h0, 16'hE800, 16'h1234, 2, 0, "R7");
    fetch(0, 2'd1, 0, 0, 32'h0000_0420, 32'h0, 16'hC123, 16'h0, 0, 0, "R7");
    fetch(0, 2'd2, 0, 1, 32'h0000_0500, 32'h0, 16'h4770, 16'h0, 1, 0, "R9");
    fetch(0, 2'd2, 0, 1, 32'h0000_0504, 32'h0, 16'hF7FF, 16'hBFFE, 1, 0, "R9");
    fetch(0, 2'd2, 0, 0, 32'h0000_0600, 32'h0, 16'h4770, 16'h0, 0, 0, "R5");
    fetch(0, 2'd1, 0, 0, 32'h0000_0700, 32'h0, 16'hF800, 16'hABCD, 3, 1, "R11");
    fetch(0, 2'd0, 0, 0, 32'h0000_0800, 32'hCAFE_F00D, 16'h0, 16'h0, 3, 1, "R11");
    fetch(0, 2'd1, 0, 0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 16'h5A5A, 1, 0, "R8");
    fetch(0, 2'd3, 1, 1, 32'h0000_0900, 32'h0, 16'h0, 16'h0, 0, 0, "R4");
    fetch(0, 2'd1, 0, 0, 32'h0000_0A00, 32'h0, 16'h2001, 16'h0, 0, 0, "R4");

    @(negedge clk);
    req_mode = 2'd1; arch_old = 0; pc = 32'h0000_0B00; start = 1;
    @(negedge clk);
    start = 0;
    chk(mem_req === 1'b1, "R1 fetch started", mem_req, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(mem_req === 0 && busy === 0 && done === 0, "R1 reset mid-fetch",
        {mem_req, busy, done}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule